// File: doc/BRIEF.md
# Serial EEPROM Byte-Write Engine with Acknowledge Polling

This block is a single-master two-wire serial bus engine that stores one byte into a serial EEPROM. A host pulses a command strobe together with an 8-bit word address and a data byte. The engine then runs a write frame: a start condition, the write-mode control byte, the word address and the data byte. Each byte goes out most significant bit first and is followed by an acknowledge clock. The frame ends with a stop condition.

The EEPROM then runs its internal write cycle, and the engine waits for it by polling. Each poll frame is a start condition followed by the same write-mode control byte. A not-acknowledge means the device is still busy, so the engine sends a stop and polls again. An acknowledge means the write has finished. The engine then closes with a start condition followed at once by a stop condition, which leaves the device in standby. If polling gets no acknowledge within the timeout window, the operation ends with an error. It also ends with an error if the device refuses any byte of the write frame.

Both bus lines are open-drain. The block only pulls a line low or releases it. The bus clock comes from the system clock through a quarter-period divider. The host sees three signals: busy, a one-cycle done pulse, and a sticky error flag.

Top module: `eeprom_bytewr_ctrl`

## Requirements
- R1: After reset, both bus lines are released (scl_drive_low = 0, sda_drive_low = 0), and busy, done and err are all 0.
- R2: A start strobe seen while idle is accepted. From the next cycle busy = 1 and err = 0. A strobe seen while busy is ignored: it changes neither the bytes written nor the number of operations.
- R3: The write frame begins with a start condition, then the control byte 0xA0 (device code 1010, select bits 000, write bit 0), then the word address. Each byte is sent MSB first, and the target acknowledges (SDA low) on the ninth clock.
- R4: The data byte is sent MSB first only after the address byte has been acknowledged. When the data byte is acknowledged, a stop condition follows.
- R5: A not-acknowledge to the control, address or data byte of the write frame causes a stop condition and no polling. The operation then ends with err = 1, and no byte is stored by the target.
- R6: After the write frame's stop, the engine sends poll frames (start, then 0xA0). After each NACKed poll it sends a stop and polls again. A target that refuses N polls therefore sees exactly N+1 polls.
- R7: An acknowledged poll is followed by a start condition and then at once by a stop condition, with no bits between them. The operation then ends with err = 0.
- R8: If a poll is NACKed after TIMEOUT_CYC clock cycles have elapsed since polling began, the operation ends with err = 1. The operation takes more than TIMEOUT_CYC cycles in total.
- R9: done is a single-cycle pulse. busy falls in the same cycle that done rises. err keeps its value until the next command is accepted.
- R10: Inside a byte, SDA changes only while SCL is low. Start and stop are the only SDA edges made while SCL is high. Every SCL high phase of a bit lasts 2*QUARTER_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted when idle |
| word_addr | input | 8 | EEPROM word address to write |
| wr_data | input | 8 | Byte to store |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| err | output | 1 | Sticky error/timeout flag of the last operation |

## Verification
A wrong bit counter or shift register shows up on the bus within one byte time. The bus model then stores the wrong address or data, or sees a start or stop condition in the middle of a byte. A sequencer that takes the wrong branch after an acknowledge shows up in the poll and closing-frame counts. These counts are checked when done pulses, so the fault is seen one operation later at most. A timer fault appears either as a spurious error on a short poll run or as a missing error after the forced timeout. The duration of that run is bounded from both sides.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  localparam int BYTE_W = 8;

  // write-mode control byte: device code 1010, select 000, R/W = 0
  localparam logic [BYTE_W-1:0] WRITE_CTRL = 8'hA0;

  typedef enum logic [1:0] {
    BC_START,
    BC_STOP,
    BC_BIT
  } bit_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_W_START,
    S_W_CTRL,
    S_W_ADDR,
    S_W_DATA,
    S_W_STOP,
    S_P_START,
    S_P_CTRL,
    S_P_STOP,
    S_C_START,
    S_C_STOP,
    S_FINISH
  } seq_state_e;

endpackage

// File: rtl/eewr_bit_engine.sv
module eewr_bit_engine
  import eewr_pkg::*;
#(
  parameter int QDIV = 312
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_valid,
  input  bit_cmd_e cmd,
  input  logic     cmd_bit,
  output logic     ready,
  output logic     done,
  output logic     rx_bit,
  input  logic     sda_in,
  output logic     scl_low,
  output logic     sda_low
);

  localparam int DW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(QDIV - 1);

  logic [1:0]    sda_sync;
  logic          active;
  logic [1:0]    phase;
  logic [DW-1:0] div;
  bit_cmd_e      cur_cmd;
  logic          cur_bit;

  // line levels per quarter phase, returned as {scl_high, sda_high}
  function automatic logic [1:0] levels(bit_cmd_e c, logic b, logic [1:0] ph);
    logic mid;
    mid = (ph == 2'd1) || (ph == 2'd2);
    case (c)
      BC_START: levels = {mid, ph < 2'd2};
      BC_STOP:  levels = {ph != 2'd0, ph >= 2'd2};
      default:  levels = {mid, b};
    endcase
  endfunction

  assign ready = !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_sync <= 2'b11;
    end else begin
      sda_sync <= {sda_sync[0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      phase   <= 2'd0;
      div     <= '0;
      cur_cmd <= BC_STOP;
      cur_bit <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      done    <= 1'b0;
      rx_bit  <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (cmd_valid) begin
          active             <= 1'b1;
          phase              <= 2'd0;
          div                <= '0;
          cur_cmd            <= cmd;
          cur_bit            <= cmd_bit;
          {scl_low, sda_low} <= ~levels(cmd, cmd_bit, 2'd0);
        end
      end else if (div == DIV_LAST) begin
        div <= '0;
        if (phase == 2'd1) rx_bit <= sda_sync[1];
        if (phase == 2'd3) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          phase              <= phase + 2'd1;
          {scl_low, sda_low} <= ~levels(cur_cmd, cur_bit, phase + 2'd1);
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  // R10: while SCL stays high, SDA may move only as part of start or stop
  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!scl_low && $past(!scl_low) && !$stable(sda_low)) |-> (cur_cmd != BC_BIT));

  // R10: completion is reported only once the engine is idle again
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !active);

endmodule

// File: rtl/eewr_poll_timer.sv
module eewr_poll_timer #(
  parameter int LIMIT = 3_750_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (cnt == CNT_LAST) begin
      expired <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: once expired during polling, the flag holds until polling stops
  p_expire_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && expired) |=> expired);

  // R8: leaving the poll phase clears the timer
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !expired);

endmodule

// File: rtl/eewr_seq.sv
module eewr_seq
  import eewr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] word_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              eng_ready,
  input  logic              eng_done,
  input  logic              eng_rx,
  input  logic              tmo_expired,
  output logic              cmd_valid,
  output bit_cmd_e          cmd,
  output logic              cmd_bit,
  output logic              tmo_run,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

  seq_state_e        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              pending;
  logic              err_pend;
  logic              last_bit;
  logic              acked;

  assign last_bit = (bitcnt == ACK_SLOT);
  assign acked    = !eng_rx;

  always_comb begin
    cmd_valid = !pending && (state != S_IDLE) && (state != S_FINISH);
    case (state)
      S_W_START, S_P_START, S_C_START: cmd = BC_START;
      S_W_STOP, S_P_STOP, S_C_STOP:    cmd = BC_STOP;
      default:                         cmd = BC_BIT;
    endcase
    cmd_bit = last_bit ? 1'b1 : shreg[BYTE_W-1];
    tmo_run = (state == S_P_START) || (state == S_P_CTRL) || (state == S_P_STOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      pending  <= 1'b0;
      err_pend <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_valid && eng_ready) pending <= 1'b1;
      if (state == S_IDLE) begin
        if (start) begin
          busy     <= 1'b1;
          err      <= 1'b0;
          err_pend <= 1'b0;
          addr_q   <= word_addr;
          data_q   <= wr_data;
          state    <= S_W_START;
        end
      end else if (state == S_FINISH) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        err   <= err_pend;
        state <= S_IDLE;
      end else if (pending && eng_done) begin
        pending <= 1'b0;
        case (state)
          S_W_START, S_P_START: begin
            state  <= (state == S_W_START) ? S_W_CTRL : S_P_CTRL;
            shreg  <= WRITE_CTRL;
            bitcnt <= '0;
          end
          S_W_CTRL, S_W_ADDR, S_W_DATA, S_P_CTRL: begin
            if (!last_bit) begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end else begin
              bitcnt <= '0;
              case (state)
                S_W_CTRL: begin
                  if (acked) begin
                    state <= S_W_ADDR;
                    shreg <= addr_q;
                  end else begin
                    err_pend <= 1'b1;
                    state    <= S_W_STOP;
                  end
                end
                S_W_ADDR: begin
                  if (acked) begin
                    state <= S_W_DATA;
                    shreg <= data_q;
                  end else begin
                    err_pend <= 1'b1;
                    state    <= S_W_STOP;
                  end
                end
                S_W_DATA: begin
                  if (!acked) err_pend <= 1'b1;
                  state <= S_W_STOP;
                end
                default: state <= acked ? S_C_START : S_P_STOP;
              endcase
            end
          end
          S_W_STOP:  state <= err_pend ? S_FINISH : S_P_START;
          S_P_STOP: begin
            if (tmo_expired) begin
              err_pend <= 1'b1;
              state    <= S_FINISH;
            end else begin
              state <= S_P_START;
            end
          end
          S_C_START: state <= S_C_STOP;
          S_C_STOP:  state <= S_FINISH;
          default:   state <= S_IDLE;
        endcase
      end
    end
  end

  // R3: a command is offered to the bit engine only when it is idle
  p_cmd_ready_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> eng_ready);

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: busy is low while done is high
  p_busy_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: an accepted command clears the error flag
  p_err_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> !err);

  // R5: polling never starts after a refused write frame
  p_no_poll_after_nack_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_P_START) |-> !err_pend);

  // R6: a refused poll without timeout leads to another poll
  p_repoll_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_P_STOP && pending && eng_done && !tmo_expired) |=> (state == S_P_START));

endmodule

// File: rtl/eeprom_bytewr_ctrl.sv
module eeprom_bytewr_ctrl
  import eewr_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int SCL_HZ      = 100_000,
  parameter int QUARTER_DIV = CLK_HZ / (4 * SCL_HZ),
  parameter int TIMEOUT_CYC = (CLK_HZ / 1000) * 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] word_addr,
  input  logic [7:0] wr_data,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  output logic       busy,
  output logic       done,
  output logic       err
);

  logic     cmd_valid;
  bit_cmd_e cmd;
  logic     cmd_bit;
  logic     eng_ready;
  logic     eng_done;
  logic     eng_rx;
  logic     tmo_run;
  logic     tmo_expired;

  eewr_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .word_addr   (word_addr),
    .wr_data     (wr_data),
    .eng_ready   (eng_ready),
    .eng_done    (eng_done),
    .eng_rx      (eng_rx),
    .tmo_expired (tmo_expired),
    .cmd_valid   (cmd_valid),
    .cmd         (cmd),
    .cmd_bit     (cmd_bit),
    .tmo_run     (tmo_run),
    .busy        (busy),
    .done        (done),
    .err         (err)
  );

  eewr_bit_engine #(.QDIV(QUARTER_DIV)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .cmd_bit   (cmd_bit),
    .ready     (eng_ready),
    .done      (eng_done),
    .rx_bit    (eng_rx),
    .sda_in    (sda_in),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low)
  );

  eewr_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (tmo_run),
    .expired (tmo_expired)
  );

endmodule

// File: tb/tb_eeprom_bytewr_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_bytewr_ctrl;

  localparam int QD  = 4;
  localparam int TMO = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] word_addr = '0;
  logic [7:0] wr_data = '0;
  logic scl_drive_low, sda_drive_low, busy, done, err;
  logic slv_drv = 1'b0;
  logic scl_bus, sda_bus;

  assign scl_bus = !scl_drive_low;
  assign sda_bus = !(sda_drive_low || slv_drv);

  always #4 clk = ~clk;

  eeprom_bytewr_ctrl #(.QUARTER_DIV(QD), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .start(start), .word_addr(word_addr), .wr_data(wr_data),
    .sda_in(sda_bus), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .busy(busy), .done(done), .err(err)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- EEPROM bus model ----------------
  int   cfg_busy_polls = 0;
  int   cfg_nack_at = 0;
  int   bitcnt = 0;
  bit   ackph = 0;
  bit   in_frame = 0;
  bit   frame_nack = 0;
  bit   poll_frame = 0;
  int   fbyte = 0;
  logic [7:0] sh = '0;
  logic [7:0] fr [3];
  bit   wbusy = 0;
  int   poll_left = 0;
  int   polls_seen = 0;
  int   empty_frames = 0;
  int   writes_seen = 0;
  int   mid_viol = 0;
  int   high_bad = 0;
  int   t_rise = 0;
  logic [7:0] got_addr = '0;
  logic [7:0] got_data = '0;

  always @(negedge sda_bus) begin
    if (scl_bus === 1'b1) begin
      if (in_frame && bitcnt >= 2 && bitcnt < 8) mid_viol++;
      in_frame   = 1;
      bitcnt     = 0;
      ackph      = 0;
      fbyte      = 0;
      frame_nack = 0;
      poll_frame = 0;
    end
  end

  always @(posedge sda_bus) begin
    if (scl_bus === 1'b1 && in_frame) begin
      if (bitcnt >= 2 && bitcnt < 8) mid_viol++;
      if (fbyte == 3 && !frame_nack && !poll_frame) begin
        writes_seen++;
        got_addr  = fr[1];
        got_data  = fr[2];
        wbusy     = 1;
        poll_left = cfg_busy_polls;
      end
      if (fbyte == 0 && bitcnt <= 1 && !ackph) empty_frames++;
      in_frame = 0;
    end
  end

  always @(posedge scl_bus) begin
    t_rise = cyc;
    if (in_frame && !ackph) begin
      sh = {sh[6:0], sda_bus};
      bitcnt++;
    end
  end

  always @(negedge scl_bus) begin
    bit ack;
    if (in_frame) begin
      if ((ackph || bitcnt >= 1) && (cyc - t_rise) != 2 * QD) high_bad++;
      if (!ackph && bitcnt == 8) begin
        fr[(fbyte < 3) ? fbyte : 2] = sh;
        ack = 1;
        if (fbyte == 0) begin
          if (sh != 8'hA0) ack = 0;
          else if (wbusy) begin
            poll_frame = 1;
            polls_seen++;
            if (poll_left > 0) begin poll_left--; ack = 0; end
            else begin ack = 1; wbusy = 0; end
          end else ack = (cfg_nack_at != 1);
        end else if (fbyte == 1) ack = (cfg_nack_at != 2);
        else if (fbyte == 2) ack = (cfg_nack_at != 3);
        if (!ack) frame_nack = 1;
        ackph   = 1;
        slv_drv = ack;
      end else if (ackph) begin
        slv_drv = 0;
        ackph   = 0;
        bitcnt  = 0;
        fbyte++;
      end
    end
  end

  // ---------------- operation task ----------------
  task automatic run_op(input logic [7:0] a, input logic [7:0] d, input int npolls,
                        input int nack_at, input bit inject, output int elapsed);
    int w0, p0, e0, t0, n;
    bit exp_err;
    w0 = writes_seen; p0 = polls_seen; e0 = empty_frames;
    cfg_busy_polls = npolls;
    cfg_nack_at    = nack_at;
    wbusy          = 0;
    @(negedge clk);
    word_addr = a; wr_data = d; start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after strobe", int'(busy), 1);
    chk(err === 1'b0, "R2", "err cleared on accept", int'(err), 0);
    n = 0;
    while (done !== 1'b1 && n < 60000) begin
      @(negedge clk);
      n++;
      if (inject && n == 150) begin
        word_addr = ~a; wr_data = ~d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n++;
      end
    end
    elapsed = cyc - t0;
    chk(done === 1'b1, "R9", "done seen", int'(done), 1);
    chk(busy === 1'b0, "R9", "busy low with done", int'(busy), 0);
    exp_err = (nack_at != 0) || (npolls > 1000);
    chk(err === exp_err, (nack_at != 0) ? "R5" : ((npolls > 1000) ? "R8" : "R7"),
        "err at done", int'(err), int'(exp_err));
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", int'(done), 0);
    if (nack_at != 0) begin
      chk(writes_seen == w0, "R5", "no store after nack", writes_seen - w0, 0);
      chk(polls_seen == p0, "R5", "no polls after nack", polls_seen - p0, 0);
    end else begin
      chk(writes_seen == w0 + 1, "R4", "one store", writes_seen - w0, 1);
      chk(got_addr == a, "R3", "address stored", int'(got_addr), int'(a));
      chk(got_data == d, "R4", "data stored", int'(got_data), int'(d));
      if (npolls <= 1000) begin
        chk(polls_seen - p0 == npolls + 1, "R6", "poll count", polls_seen - p0, npolls + 1);
        chk(empty_frames - e0 == 1, "R7", "closing start+stop", empty_frames - e0, 1);
      end else begin
        chk(empty_frames - e0 == 0, "R8", "no close on timeout", empty_frames - e0, 0);
        chk(polls_seen - p0 >= 2, "R8", "several polls before timeout", polls_seen - p0, 2);
      end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d cycles max", cyc, 200000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int el;
    int w0;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_drive_low === 1'b0, "R1", "scl released", int'(scl_drive_low), 0);
    chk(sda_drive_low === 1'b0, "R1", "sda released", int'(sda_drive_low), 0);
    chk(busy === 1'b0, "R1", "busy", int'(busy), 0);
    chk(done === 1'b0, "R1", "done", int'(done), 0);
    chk(err === 1'b0, "R1", "err", int'(err), 0);

    // directed: immediate ack, one and three refused polls
    run_op(8'h5A, 8'hC3, 0, 0, 0, el);
    run_op(8'h00, 8'hFF, 1, 0, 0, el);
    run_op(8'hFF, 8'h00, 3, 0, 0, el);

    // directed: refusal at each write byte, then sticky err and clear
    run_op(8'h12, 8'h34, 0, 1, 0, el);
    repeat (20) @(negedge clk);
    chk(err === 1'b1, "R9", "err sticky while idle", int'(err), 1);
    run_op(8'h56, 8'h78, 0, 2, 0, el);
    run_op(8'h9A, 8'hBC, 0, 3, 0, el);
    run_op(8'h81, 8'h7E, 0, 0, 0, el);

    // R2: strobe during an operation is ignored
    w0 = writes_seen;
    run_op(8'h3C, 8'hA5, 2, 0, 1, el);
    repeat (600) @(negedge clk);
    chk(busy === 1'b0, "R2", "no second operation", int'(busy), 0);
    chk(writes_seen == w0 + 1, "R2", "single store despite strobe", writes_seen - w0, 1);

    // R8: device never finishes
    run_op(8'h44, 8'h99, 100000, 0, 0, el);
    chk(el > TMO, "R8", "timeout duration lower", el, TMO);
    chk(el < TMO + 2000, "R8", "timeout duration upper", el, TMO + 2000);

    // random mix
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ra, rd;
      int np, na;
      ra = 8'($urandom);
      rd = 8'($urandom);
      np = int'($urandom % 4);
      na = (($urandom % 4) == 0) ? int'(1 + $urandom % 3) : 0;
      run_op(ra, rd, np, na, 0, el);
    end

    chk(mid_viol == 0, "R10", "start/stop inside byte", mid_viol, 0);
    chk(high_bad == 0, "R10", "scl high phase length", high_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule